// File: doc/BRIEF.md
# Five-Pin Bidirectional I/O Port with Peripheral Takeover

This block is a small general-purpose I/O port of five pins, driven by a register bus with three addressable registers: a pin-level register, an output latch register and a direction register. Software sets each pin to drive or to float through the direction register. The output latch holds the value driven on pins that software owns. Reads of the pin-level register return the synchronised level seen on the pins, while reads of the latch return what was stored.

Any pin can be handed to an on-chip peripheral through a per-pin select. While selected, the peripheral supplies both the pin data and the pin drive enable, but the direction register is left untouched. Software can therefore do read-modify-write on the direction register while peripherals own some of the pins. The pad itself is modelled as a drive enable, a drive value and a sampled input. The input feeds both the port read path and the per-pin data returned to the peripherals.

Top module: `gpio_ovr_port`

## Requirements
- R1: After reset every direction bit reads 1, the output latch reads 0, and no pin is driven (pin_oe all 0 while no select is active).
- R2: A write to address 0 or address 1 stores wdata[4:0] into the output latch on the next clock edge, and a read of address 1 returns the latch in rdata[4:0].
- R3: A write to address 2 stores wdata[4:0] into the direction register, and a read of address 2 returns it in rdata[4:0].
- R4: For a pin whose select is low, pin_out equals its latch bit and pin_oe equals the inverse of its direction bit (direction 1 means input, pad not driven).
- R5: For a pin whose select is high, pin_out equals its peripheral data bit and pin_oe equals its peripheral enable bit.
- R6: A peripheral enable bit has no effect on pin_oe while that pin's select is low.
- R7: Peripheral select and enable never change the direction register; a read of address 2 returns only what software wrote.
- R8: A read of address 0 and the per_din outputs both return pin_in as sampled two clock edges earlier.
- R9: rdata[7:5] always read 0; a read of address 3 returns 0 and a write to address 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address: 0 pin level, 1 latch, 2 direction, 3 unused |
| bus_we | input | 1 | Write strobe, acts on the rising clock edge |
| bus_wdata | input | 8 | Write data, bits 4:0 used |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| per_sel | input | 5 | Per-pin peripheral takeover select |
| per_oe | input | 5 | Per-pin peripheral drive enable |
| per_dout | input | 5 | Per-pin peripheral output data |
| per_din | output | 5 | Per-pin synchronised pin level for peripherals |
| pin_in | input | 5 | Level seen on the pad |
| pin_oe | output | 5 | Pad drive enable |
| pin_out | output | 5 | Pad drive value |

## Verification
The hardest case is a pin under peripheral takeover with its peripheral enable differing from the inverse of its direction bit, while software rewrites the direction register in the same window; only then can a leak of the override into the register, or of the stored direction into the pad, be seen. Random stimulus toggles select, enable and direction writes independently every cycle so these mixes arise often, and a directed step holds all selects high with enables set, rewrites the direction register and reads it back. Pin-level reads are compared against a two-deep history of pin_in kept in the bench.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    REG_PINS  = 2'd0,
    REG_LATCH = 2'd1,
    REG_DIR   = 2'd2,
    REG_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_ovr_regs.sv
module gpio_ovr_regs
  import gpio_ovr_pkg::*;
#(
  parameter int unsigned NPINS = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NPINS-1:0]  pins_sync,
  output logic [NPINS-1:0]  tris_q,
  output logic [NPINS-1:0]  lat_q,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned PAD_W = DATA_W - NPINS;

  reg_sel_e sel;
  logic     wr_lat;
  logic     wr_dir;

  assign sel    = reg_sel_e'(addr);
  assign wr_lat = we && (sel == REG_PINS || sel == REG_LATCH);
  assign wr_dir = we && (sel == REG_DIR);

  // Direction resets to all inputs
  always_ff @(posedge clk) begin
    if (rst) begin
      tris_q <= '1;
    end else if (wr_dir) begin
      tris_q <= wdata[NPINS-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q <= '0;
    end else if (wr_lat) begin
      lat_q <= wdata[NPINS-1:0];
    end
  end

  always_comb begin
    unique case (sel)
      REG_PINS:  rdata = {{PAD_W{1'b0}}, pins_sync};
      REG_LATCH: rdata = {{PAD_W{1'b0}}, lat_q};
      REG_DIR:   rdata = {{PAD_W{1'b0}}, tris_q};
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_ovr_sync.sv
module gpio_ovr_sync #(
  parameter int unsigned NPINS  = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] d,
  output logic [NPINS-1:0] q
);
  genvar i;
  generate
    for (i = 0; i < NPINS; i++) begin : g_pin
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) begin
          chain <= '0;
        end else begin
          chain <= {chain[STAGES-2:0], d[i]};
        end
      end
      assign q[i] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/gpio_ovr_padmux.sv
module gpio_ovr_padmux #(
  parameter int unsigned NPINS = 5
) (
  input  logic [NPINS-1:0] tris_q,
  input  logic [NPINS-1:0] lat_q,
  input  logic [NPINS-1:0] per_sel,
  input  logic [NPINS-1:0] per_oe,
  input  logic [NPINS-1:0] per_dout,
  output logic [NPINS-1:0] pin_oe,
  output logic [NPINS-1:0] pin_out
);
  genvar i;
  generate
    for (i = 0; i < NPINS; i++) begin : g_pin
      // Peripheral enable only counts while the pin is taken over
      assign pin_oe[i]  = per_sel[i] ? per_oe[i]   : ~tris_q[i];
      assign pin_out[i] = per_sel[i] ? per_dout[i] : lat_q[i];
    end
  endgenerate
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
  import gpio_ovr_pkg::*;
#(
  parameter int unsigned NPINS       = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  per_sel,
  input  logic [NPINS-1:0]  per_oe,
  input  logic [NPINS-1:0]  per_dout,
  output logic [NPINS-1:0]  per_din,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  pin_out
);
  logic [NPINS-1:0] pins_sync;
  logic [NPINS-1:0] tris_q;
  logic [NPINS-1:0] lat_q;

  gpio_ovr_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pins_sync)
  );

  gpio_ovr_regs #(.NPINS(NPINS)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .addr      (bus_addr),
    .we        (bus_we),
    .wdata     (bus_wdata),
    .pins_sync (pins_sync),
    .tris_q    (tris_q),
    .lat_q     (lat_q),
    .rdata     (bus_rdata)
  );

  gpio_ovr_padmux #(.NPINS(NPINS)) u_mux (
    .tris_q   (tris_q),
    .lat_q    (lat_q),
    .per_sel  (per_sel),
    .per_oe   (per_oe),
    .per_dout (per_dout),
    .pin_oe   (pin_oe),
    .pin_out  (pin_out)
  );

  assign per_din = pins_sync;
endmodule

// File: rtl/gpio_ovr_port_chk.sv
module gpio_ovr_port_chk #(
  parameter int unsigned NPINS = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       bus_addr,
  input logic             bus_we,
  input logic [7:0]       bus_rdata,
  input logic [NPINS-1:0] per_sel,
  input logic [NPINS-1:0] per_din,
  input logic [NPINS-1:0] pin_in,
  input logic [NPINS-1:0] pin_oe,
  input logic [NPINS-1:0] tris_q,
  input logic [NPINS-1:0] lat_q
);
  logic [1:0] settle;
  always_ff @(posedge clk) begin
    if (rst) settle <= '0;
    else if (settle != 2'd3) settle <= settle + 2'd1;
  end

  // R1: reset leaves all pins as inputs and the latch cleared
  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (tris_q == '1 && lat_q == '0));

  // R2: latch only moves on a write to address 0 or 1
  a_r2_latch_hold: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && (bus_addr == 2'd0 || bus_addr == 2'd1)) |=> $stable(lat_q));

  // R7: direction only moves on a software write to address 2
  a_r7_dir_hold: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_addr == 2'd2) |=> $stable(tris_q));

  // R6: unselected pins are driven only when their direction bit is 0
  a_r6_unsel_oe: assert property (@(posedge clk) disable iff (rst)
    (pin_oe & ~per_sel) == (~tris_q & ~per_sel));

  // R8: peripheral input is the pin two edges ago
  a_r8_sync_delay: assert property (@(posedge clk) disable iff (rst)
    (settle == 2'd3) |-> (per_din == $past(pin_in, 2)));

  // R9: unused read bits are zero
  a_r9_upper_zero: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[7:5] == 3'b000);
endmodule

bind gpio_ovr_port gpio_ovr_port_chk #(.NPINS(NPINS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_rdata (bus_rdata),
  .per_sel   (per_sel),
  .per_din   (per_din),
  .pin_in    (pin_in),
  .pin_oe    (pin_oe),
  .tris_q    (tris_q),
  .lat_q     (lat_q)
);

// File: tb/gpio_ovr_port_tb.sv
module gpio_ovr_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 5;

  logic         clk = 1'b0;
  logic         rst;
  logic [1:0]   bus_addr;
  logic         bus_we;
  logic [7:0]   bus_wdata;
  logic [7:0]   bus_rdata;
  logic [N-1:0] per_sel, per_oe, per_dout, per_din;
  logic [N-1:0] pin_in, pin_oe, pin_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [N-1:0] m_tris, m_lat, m_s1, m_s2;

  gpio_ovr_port u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .per_sel(per_sel),
    .per_oe(per_oe), .per_dout(per_dout), .per_din(per_din),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] exp_rdata(input logic [1:0] a);
    case (a)
      2'd0:    return {3'b000, m_s2};
      2'd1:    return {3'b000, m_lat};
      2'd2:    return {3'b000, m_tris};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_edge();
    if (bus_we) begin
      if (bus_addr == 2'd0 || bus_addr == 2'd1) m_lat = bus_wdata[N-1:0];
      else if (bus_addr == 2'd2) m_tris = bus_wdata[N-1:0];
    end
    m_s2 = m_s1;
    m_s1 = pin_in;
  endtask

  task automatic check_all();
    check("R4 pin_out", {3'b0, pin_out & ~per_sel}, {3'b0, m_lat & ~per_sel});
    check("R4 pin_oe", {3'b0, pin_oe & ~per_sel}, {3'b0, ~m_tris & ~per_sel});
    check("R5 pin_out", {3'b0, pin_out & per_sel}, {3'b0, per_dout & per_sel});
    check("R5 pin_oe", {3'b0, pin_oe & per_sel}, {3'b0, per_oe & per_sel});
    check("R8 per_din", {3'b0, per_din}, {3'b0, m_s2});
    case (bus_addr)
      2'd0: check("R8 read", bus_rdata, exp_rdata(bus_addr));
      2'd1: check("R2 read", bus_rdata, exp_rdata(bus_addr));
      2'd2: check("R3 read", bus_rdata, exp_rdata(bus_addr));
      default: check("R9 read", bus_rdata, exp_rdata(bus_addr));
    endcase
  endtask

  // One cycle: drive at negedge, check combinational view, apply the edge
  task automatic step(input logic [1:0] a, input logic w, input logic [7:0] d,
                      input logic [N-1:0] s, input logic [N-1:0] oe,
                      input logic [N-1:0] dout, input logic [N-1:0] pin);
    @(negedge clk);
    bus_addr = a; bus_we = w; bus_wdata = d;
    per_sel = s; per_oe = oe; per_dout = dout; pin_in = pin;
    #1;
    check_all();
    model_edge();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7341));
    rst = 1'b1; bus_addr = 2'd0; bus_we = 1'b0; bus_wdata = '0;
    per_sel = '0; per_oe = '0; per_dout = '0; pin_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_tris = '1; m_lat = '0; m_s1 = '0; m_s2 = '0;
    #1;
    // R1 reset state through the ports
    bus_addr = 2'd2; #1;
    check("R1 dir", bus_rdata, 8'h1F);
    bus_addr = 2'd1; #1;
    check("R1 latch", bus_rdata, 8'h00);
    check("R1 pin_oe", {3'b0, pin_oe}, 8'h00);

    // R2 via address 0 then address 1
    step(2'd0, 1'b1, 8'hF5, '0, '0, '0, '0);
    step(2'd1, 1'b0, 8'h00, '0, '0, '0, '0);
    step(2'd1, 1'b1, 8'h0A, '0, '0, '0, '0);
    step(2'd1, 1'b0, 8'h00, '0, '0, '0, '0);
    // R3 direction write, R4 drive
    step(2'd2, 1'b1, 8'hE4, '0, '0, '0, '0);
    step(2'd2, 1'b0, 8'h00, '0, '0, '0, '0);
    // R6 peripheral enable ignored while unselected
    step(2'd2, 1'b0, 8'h00, 5'b00000, 5'b11111, 5'b11111, '0);
    check("R6 oe", {3'b0, pin_oe}, {3'b0, ~m_tris});
    // R7 override active while software rewrites direction
    step(2'd2, 1'b1, 8'h13, 5'b11111, 5'b10101, 5'b01010, '0);
    step(2'd2, 1'b0, 8'h00, 5'b11111, 5'b01010, 5'b11111, '0);
    check("R7 dir", bus_rdata, 8'h13);
    // R9 write to address 3 changes nothing
    step(2'd3, 1'b1, 8'hFF, '0, '0, '0, 5'b10110);
    step(2'd2, 1'b0, 8'h00, '0, '0, '0, 5'b10110);
    check("R9 dir kept", bus_rdata, 8'h13);
    step(2'd1, 1'b0, 8'h00, '0, '0, '0, 5'b10110);
    check("R9 latch kept", bus_rdata, 8'h0A);
    // R8 pin level after two edges
    step(2'd0, 1'b0, 8'h00, '0, '0, '0, 5'b10110);
    check("R8 pins", bus_rdata, 8'h16);

    for (int k = 0; k < 3000; k++) begin
      step(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 8'($urandom),
           N'($urandom), N'($urandom), N'($urandom), N'($urandom));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule